// File: doc/BRIEF.md
# Fan PWM Controller with Tachometer

This block drives one cooling fan from a single pulse-width-modulated output and measures how fast the fan turns from its tachometer line. Software programs it through a small 32-bit register bus with two control words and one read-only status word. The PWM period is not programmable. A mode bit picks one of two fixed periods: a long one for fans with two or three wires and a short one for four-wire fans. An 8-bit duty value sets the high time. Any duty value below a floor of 51/255 (20%) is raised to the floor, and 0xFF keeps the output high for the whole period.

In four-wire mode, with the tach enable bit set, the block synchronises the tachometer input and counts its rising edges over a fixed gate window. It scales the count to revolutions per minute, divides by the selected number of pulses per revolution (two or four), and saturates the result into a 16-bit status field. Duty and mode changes take effect only at a period boundary, so no period ever mixes two settings.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: After reset all control fields are zero, pwm_o is low and every register reads zero.
- R2: Control word A is at byte offset 0x0 with en in bit 0, mode in bit 1 (1 = short period), pwm_off in bit 2, tach_on in bit 4, ppr4 in bit 5 (1 = four pulses per revolution) and duty in bits 23:16. Control word B is at 0x4 with a 16-bit max-speed field in bits 15:0. Status is at 0x10 with speed in bits 15:0. Unused bits and unmapped offsets read zero.
- R3: The period is P_SHORT cycles when mode=1 and P_LONG cycles when mode=0. Each period holds exactly ceil(d*P/255) high cycles, where d is the effective duty.
- R4: A duty of 0xFF keeps pwm_o high for every cycle of the period.
- R5: A programmed duty below 51 behaves exactly as a duty of 51.
- R6: pwm_o stays low while en=0 or pwm_off=1. After the output is re-enabled, a fresh period starts with its high phase, in the second cycle after the write.
- R7: New duty and mode values are taken only at a period boundary. A period that has already started finishes with the old setting.
- R8: Speed is measured only when tach_on=1 and mode=1. Otherwise the status speed reads zero.
- R9: At the end of each GATE_CYC-cycle window, speed is set to (rising tach edges in the window) * RPM_MULT / 2, or / 4 when ppr4=1.
- R10: A speed result above 0xFFFF reads as 0xFFFF.
- R11: Writes to the status offset have no effect on the reported speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as a read strobe, zero otherwise |
| tach_i | input | 1 | Tachometer input from the fan (asynchronous) |
| pwm_o | output | 1 | Fan PWM output |

## Verification
The interaction that matters most is a duty write that arrives while a period is in progress, since the write and the next period boundary compete for the duty holding register. The bench aligns itself to a period by re-enabling the output and then writes full duty six cycles into that period. It expects the running period to keep the old high count and the following period to carry the new one. A similar collision on the measurement side is a status write that lands while a speed result is held. The bench judges it by reading the same value back before and after the write, inside one gate window.

// File: rtl/fan_pkg.sv
package fan_pkg;
  localparam logic [7:0] DUTY_FLOOR = 8'd51;
  localparam logic [7:0] DUTY_MAX   = 8'hFF;
  localparam int unsigned OFF_CTRL_A = 32'h0;
  localparam int unsigned OFF_CTRL_B = 32'h4;
  localparam int unsigned OFF_STAT   = 32'h10;

  typedef struct packed {
    logic [7:0] duty;
    logic       ppr4;
    logic       tach_on;
    logic       pwm_off;
    logic       mode;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/fan_regs.sv
module fan_regs
  import fan_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  input  logic [15:0]   speed_i,
  output logic [31:0]   rdata_o,
  output ctrl_t         ctrl_o
);
  ctrl_t       ctrl_q;
  logic [15:0] maxspd_q;
  logic        wr, rd;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      maxspd_q <= '0;
    end else if (wr) begin
      if (32'(addr_i) == OFF_CTRL_A) begin
        ctrl_q.en      <= wdata_i[0];
        ctrl_q.mode    <= wdata_i[1];
        ctrl_q.pwm_off <= wdata_i[2];
        ctrl_q.tach_on <= wdata_i[4];
        ctrl_q.ppr4    <= wdata_i[5];
        ctrl_q.duty    <= wdata_i[23:16];
      end else if (32'(addr_i) == OFF_CTRL_B) begin
        maxspd_q <= wdata_i[15:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (32'(addr_i) == OFF_CTRL_A)
        rdata_o = {8'h0, ctrl_q.duty, 10'h0, ctrl_q.ppr4, ctrl_q.tach_on,
                   1'b0, ctrl_q.pwm_off, ctrl_q.mode, ctrl_q.en};
      else if (32'(addr_i) == OFF_CTRL_B)
        rdata_o = {16'h0, maxspd_q};
      else if (32'(addr_i) == OFF_STAT)
        rdata_o = {16'h0, speed_i};
    end
  end

  assign ctrl_o = ctrl_q;

  // R2: a write to the status offset leaves both control words unchanged
  a_r2_stat_wr_no_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && 32'(addr_i) == OFF_STAT) |=> ($stable(ctrl_q) && $stable(maxspd_q)));
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fan_pkg::*;
#(
  parameter int unsigned P_LONG  = 4_000_000,
  parameter int unsigned P_SHORT = 4_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       mode_i,
  input  logic [7:0] duty_i,
  output logic       pwm_o
);
  localparam int unsigned PMAX = (P_LONG > P_SHORT) ? P_LONG : P_SHORT;
  localparam int unsigned CW   = $clog2(PMAX + 1);
  localparam int unsigned MW   = CW + 8;

  logic          run_q, mode_q;
  logic [7:0]    duty_q, duty_eff;
  logic [CW-1:0] cnt_q, per_q;
  logic [MW-1:0] pos_scaled, thr;

  assign duty_eff = (duty_i < DUTY_FLOOR) ? DUTY_FLOOR : duty_i;
  assign per_q    = mode_q ? CW'(P_SHORT) : CW'(P_LONG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      duty_q <= DUTY_FLOOR;
      mode_q <= 1'b0;
    end else if (!active_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q || cnt_q == per_q - 1'b1) begin
      run_q  <= 1'b1;
      cnt_q  <= '0;
      duty_q <= duty_eff;   // settings taken only at a boundary
      mode_q <= mode_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // high while cnt*255 < duty*period -> ceil(duty*P/255) cycles, 0xFF = 100%
  assign pos_scaled = MW'(cnt_q) * MW'(255);
  assign thr        = MW'(duty_q) * MW'(per_q);
  assign pwm_o      = run_q && (pos_scaled < thr);

  a_r6_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !pwm_o);
  a_r5_floor_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (duty_q >= DUTY_FLOOR));
  a_r7_mid_period_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q != '0) |-> ($stable(duty_q) && $stable(mode_q)));
  a_r3_cnt_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < per_q));
  a_r4_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && duty_q == DUTY_MAX) |-> pwm_o);
endmodule

// File: rtl/fan_tach.sv
module fan_tach #(
  parameter int unsigned GATE_CYC = 100_000_000,
  parameter int unsigned RPM_MULT = 60
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tach_i,
  input  logic        active_i,
  input  logic        ppr4_i,
  output logic [15:0] speed_o
);
  localparam int unsigned GW  = $clog2(GATE_CYC + 1);
  localparam int unsigned MLW = $clog2(RPM_MULT + 1);
  localparam int unsigned PW  = 16 + MLW;

  logic [2:0]    sync_q;
  logic          rise;
  logic [GW-1:0] gate_q;
  logic [15:0]   pulses_q, pulses_n, speed_q;
  logic [PW-1:0] prod, scaled;
  logic [15:0]   speed_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], tach_i};
  end
  assign rise = sync_q[1] & ~sync_q[2];

  assign pulses_n = (rise && pulses_q != 16'hFFFF) ? pulses_q + 1'b1 : pulses_q;
  assign prod     = PW'(pulses_n) * PW'(RPM_MULT);
  assign scaled   = ppr4_i ? (prod >> 2) : (prod >> 1);
  assign speed_n  = (|scaled[PW-1:16]) ? 16'hFFFF : scaled[15:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q   <= '0;
      pulses_q <= '0;
      speed_q  <= '0;
    end else if (!active_i) begin
      gate_q   <= '0;
      pulses_q <= '0;
      speed_q  <= '0;
    end else if (gate_q == GW'(GATE_CYC - 1)) begin
      gate_q   <= '0;
      pulses_q <= '0;
      speed_q  <= speed_n;
    end else begin
      gate_q   <= gate_q + 1'b1;
      pulses_q <= pulses_n;
    end
  end

  assign speed_o = speed_q;

  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (speed_o == 16'h0));
  a_r9_update_at_gate_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && $past(active_i) && gate_q != '0) |-> $stable(speed_o));
endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
  import fan_pkg::*;
#(
  parameter int unsigned AW       = 5,
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned P_LONG   = CLK_HZ / 25,
  parameter int unsigned P_SHORT  = CLK_HZ / 25_000,
  parameter int unsigned GATE_CYC = CLK_HZ,
  parameter int unsigned RPM_MULT = (CLK_HZ / GATE_CYC) * 60
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          tach_i,
  output logic          pwm_o
);
  ctrl_t       ctrl;
  logic [15:0] speed;
  logic        pwm_act, tach_act;

  assign pwm_act  = ctrl.en & ~ctrl.pwm_off;
  assign tach_act = ctrl.tach_on & ctrl.mode;

  fan_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .speed_i(speed), .rdata_o, .ctrl_o(ctrl)
  );

  fan_pwm_gen #(.P_LONG(P_LONG), .P_SHORT(P_SHORT)) u_pwm (
    .clk_i, .rst_ni, .active_i(pwm_act), .mode_i(ctrl.mode),
    .duty_i(ctrl.duty), .pwm_o
  );

  fan_tach #(.GATE_CYC(GATE_CYC), .RPM_MULT(RPM_MULT)) u_tach (
    .clk_i, .rst_ni, .tach_i, .active_i(tach_act), .ppr4_i(ctrl.ppr4),
    .speed_o(speed)
  );
endmodule

// File: tb/fan_pwm_ctrl_bench.sv
module fan_pwm_ctrl_bench;
  localparam int unsigned AW = 5;
  localparam int unsigned PL = 100;
  localparam int unsigned PS = 20;
  localparam int unsigned GATE = 1000;
  localparam int unsigned MULT = 600;
  localparam int NV = 9;
  // stimulus: mode, duty ; expected high cycles per period = ceil(max(d,51)*P/255)
  localparam logic       V_MODE [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [7:0] V_DUTY [NV] = '{8'h0A, 8'h33, 8'h34, 8'h80, 8'hFF, 8'h33, 8'hC8, 8'hFF, 8'h00};
  localparam int         V_HI   [NV] = '{4, 4, 5, 11, 20, 20, 79, 100, 20};

  logic clk_i = 0, rst_ni = 0, req_i = 0, we_i = 0, tach_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic pwm_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  fan_pwm_ctrl #(.AW(AW), .P_LONG(PL), .P_SHORT(PS), .GATE_CYC(GATE), .RPM_MULT(MULT))
    u_fan_pwm_ctrl (.*);

  always #5 clk_i = ~clk_i;

  function automatic logic [31:0] ctl(logic [7:0] d, logic ppr, logic tach, logic off, logic md, logic en);
    return {8'h0, d, 10'h0, ppr, tach, 1'b0, off, md, en};
  endfunction

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); req_i = 0; we_i = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i); req_i = 0;
  endtask

  task automatic count_high(int p, output int hi);
    hi = 0;
    repeat (p) begin @(negedge clk_i); if (pwm_o) hi++; end
  endtask

  task automatic pulses(int n, int half);
    for (int i = 0; i < n; i++) begin
      tach_i = 1; repeat (half) @(negedge clk_i);
      tach_i = 0; repeat (half) @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (150_000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int hi, h1, h2;
    bit first_hi;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check("R1 pwm in reset", {31'h0, pwm_o}, 0);
    rst_ni = 1;
    rd(5'h0, r);  check("R1 ctrl A", r, 0);
    rd(5'h4, r);  check("R1 ctrl B", r, 0);
    rd(5'h10, r); check("R1 status", r, 0);
    check("R1 pwm after reset", {31'h0, pwm_o}, 0);

    // R2 map and unused bits
    wr(5'h0, 32'hFFFF_FFFF); rd(5'h0, r); check("R2 ctrl A mask", r, 32'h00FF_0037);
    wr(5'h4, 32'hFFFF_FFFF); rd(5'h4, r); check("R2 ctrl B mask", r, 32'h0000_FFFF);
    rd(5'h8, r); check("R2 unmapped", r, 0);
    wr(5'h0, 0);

    // R3/R4/R5 table walk
    for (int i = 0; i < NV; i++) begin
      wr(5'h0, ctl(V_DUTY[i], 0, 0, 0, V_MODE[i], 1));
      repeat (2 * PL + 4) @(negedge clk_i);
      count_high(V_MODE[i] ? PS : PL, hi);
      check($sformatf("R3/R4/R5 vec%0d duty %0h", i, V_DUTY[i]), hi, V_HI[i]);
    end

    // R6 off paths
    wr(5'h0, ctl(8'hFF, 0, 0, 1, 1, 1));
    repeat (4) @(negedge clk_i); count_high(PL, hi); check("R6 pwm_off low", hi, 0);
    wr(5'h0, ctl(8'hFF, 0, 0, 0, 1, 0));
    repeat (4) @(negedge clk_i); count_high(PL, hi); check("R6 en=0 low", hi, 0);

    // R7 mid-period duty write, R6 restart phase
    wr(5'h0, ctl(8'h80, 0, 0, 0, 1, 0));
    wr(5'h0, ctl(8'h80, 0, 0, 0, 1, 1));
    h1 = 0; h2 = 0; first_hi = 0;
    for (int i = 0; i < 2 * PS; i++) begin
      @(negedge clk_i);
      if (i == 0) first_hi = pwm_o;
      if (pwm_o) begin if (i < PS) h1++; else h2++; end
      if (i == 5) begin req_i = 1; we_i = 1; addr_i = 5'h0; wdata_i = ctl(8'hFF, 0, 0, 0, 1, 1); end
      if (i == 6) begin req_i = 0; we_i = 0; end
    end
    check("R6 restart high", {31'h0, first_hi}, 1);
    check("R7 old period kept", h1, 11);
    check("R7 new period", h2, PS);
    wr(5'h0, 0);

    // R9 speed, ppr 2
    wr(5'h0, ctl(8'h0, 0, 1, 0, 1, 0));
    pulses(10, 10); repeat (900) @(negedge clk_i);
    rd(5'h10, r); check("R9 ppr2 speed", r, 32'd3000);
    wr(5'h10, 32'hFFFF); rd(5'h10, r); check("R11 status write ignored", r, 32'd3000);
    // R9 ppr 4
    wr(5'h0, 0); wr(5'h0, ctl(8'h0, 1, 1, 0, 1, 0));
    pulses(10, 10); repeat (900) @(negedge clk_i);
    rd(5'h10, r); check("R9 ppr4 speed", r, 32'd1500);
    // R10 saturation and exact value at ppr4
    wr(5'h0, 0); wr(5'h0, ctl(8'h0, 0, 1, 0, 1, 0));
    pulses(230, 2); repeat (180) @(negedge clk_i);
    rd(5'h10, r); check("R10 saturate", r, 32'hFFFF);
    wr(5'h0, 0); wr(5'h0, ctl(8'h0, 1, 1, 0, 1, 0));
    pulses(230, 2); repeat (180) @(negedge clk_i);
    rd(5'h10, r); check("R9 ppr4 large", r, 32'd34500);
    // R8 inactive in long-period mode
    wr(5'h0, ctl(8'h0, 0, 1, 0, 0, 0));
    pulses(10, 10); repeat (900) @(negedge clk_i);
    rd(5'h10, r); check("R8 mode0 no speed", r, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule